// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block moves 18-bit words from a write clock domain to an unrelated read clock domain. Each side has an active-low enable. A static mode input picks one of two read behaviours. In standard mode a word reaches the output only when it is read explicitly. In fall-through mode the oldest stored word is placed on the output on its own, and an output register adds one word of capacity on top of the core memory.

Read and write positions cross between the domains as Gray codes through two-flop synchronisers. The write side drives the full indication, almost-full (threshold set by an offset m) and half-full. The read side drives the empty indication and almost-empty (threshold set by an offset n). The two offsets load in parallel on the write clock. A full reset clears the data path and restores the default offsets. A partial reset clears the data path and keeps the programmed offsets. Both resets are synchronous and active low, and each is held for several cycles of the slower clock. The mode input and the offsets change only while both ports are idle.

Top module: `xclk_fifo`

## Requirements
- R1: While or after a full or partial reset in standard mode (`ft_mode`=0), `rd_flag`=0 (empty), `wr_flag`=1 (not full), `almost_empty`=1, `almost_full`=0, `half_full`=0 and `q`=0.
- R2: While or after a reset in fall-through mode (`ft_mode`=1), `rd_flag`=1 (no word on the output) and `wr_flag`=0 (space available).
- R3: In standard mode a written word does not appear on `q` until a read. `rd_flag` rises to 1 by the third `rclk` edge after the write edge. Each read (`ren_n`=0 while `rd_flag`=1) loads the oldest word into `q` at that `rclk` edge, in write order.
- R4: In fall-through mode the first written word appears on `q` with `rd_flag`=0 by the fourth `rclk` edge after the write, with no read enable. Each read while `rd_flag`=0 consumes the word on `q`, and the next stored word replaces it at the same edge.
- R5: Capacity is 2^ADDR_W words in standard mode and 2^ADDR_W+1 in fall-through mode. When full, `wr_flag` is 0 in standard mode and 1 in fall-through mode.
- R6: A write attempted while full is dropped: no stored word changes and no extra word is ever read.
- R7: After a read from a full FIFO, the full indication clears by the third `wclk` edge.
- R8: `almost_empty` is 1 while the stored word count (including the fall-through output word) is at most n, and 0 once the count exceeds n.
- R9: `almost_full` is 1 while count >= T-m, where T is the capacity of R5. `half_full` is 1 while count > floor(T/2).
- R10: A read while no word is available (standard mode with `rd_flag`=0, or fall-through mode with `rd_flag`=1) leaves `q` and the stored order unchanged.
- R11: A partial reset (`prst_n`=0) discards the stored words and keeps the programmed offsets. A full reset (`rst_n`=0) discards the words and restores n=2 and m=2.
- R12: `cfg_ld`=1 at a `wclk` edge loads n from `cfg_ae_off` and m from `cfg_af_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Full reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low, keeps offsets |
| ft_mode | input | 1 | 0 = standard, 1 = fall-through (static) |
| wen_n | input | 1 | Write enable, active low |
| din | input | DATA_W (18) | Write data |
| ren_n | input | 1 | Read enable, active low |
| cfg_ld | input | 1 | Load offsets on `wclk` |
| cfg_ae_off | input | ADDR_W+1 | Almost-empty offset n |
| cfg_af_off | input | ADDR_W+1 | Almost-full offset m |
| q | output | DATA_W (18) | Output word register |
| rd_flag | output | 1 | Standard: 1 = data available; fall-through: 0 = word valid on q |
| wr_flag | output | 1 | Standard: 0 = full; fall-through: 1 = full |
| almost_empty | output | 1 | Count at most n (read domain) |
| almost_full | output | 1 | Count at least T-m (write domain) |
| half_full | output | 1 | Count above floor(T/2) (write domain) |

## Verification
A write edge reaches the read side after two `rclk` edges. The standard empty indication clears there, and the fall-through output is loaded one `rclk` edge later. A read reaches the full, almost-full and half-full flags after two `wclk` edges. Almost-empty follows a read at the same `rclk` edge. One extra destination edge is allowed in each case because the clock phases are unrelated. Each flag is therefore sampled only after six cycles of the domain that produces it. The scoreboard compares `q` at the falling `rclk` edge that follows a standard read edge. In fall-through mode it compares at the falling edge just before the consuming edge.

// File: rtl/xclk_fifo_pkg.sv
// Shared helpers for the dual-clock FIFO.
// Assumes: pointer widths never exceed 32 bits.
package xclk_fifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i + 1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xclk_sync.sv
// Two-flop synchroniser for a Gray-coded pointer.
// Assumes: the input changes by at most one bit between destination edges.
module xclk_sync #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Capture the foreign pointer through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/xclk_wr_side.sv
// Write-domain control: write pointer, full, almost-full, half-full and
// the offset registers.
// Assumes: rgray_s and relgray_s are already synchronised to wclk;
// the offsets change only while both ports are idle.
module xclk_wr_side
    import xclk_fifo_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DEF_AE_OFF = 2,
    parameter int unsigned DEF_AF_OFF = 2,
    localparam int unsigned PTR_W     = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              ft_mode,
    input  logic              wen_n,
    input  logic              cfg_ld,
    input  logic [PTR_W-1:0]  cfg_ae_off,
    input  logic [PTR_W-1:0]  cfg_af_off,
    input  logic [PTR_W-1:0]  rgray_s,
    input  logic [PTR_W-1:0]  relgray_s,
    output logic [PTR_W-1:0]  wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              we,
    output logic              full_core,
    output logic              wr_flag,
    output logic              almost_full,
    output logic              half_full,
    output logic [PTR_W-1:0]  ae_off
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned CNT_W = ADDR_W + 2;

    logic              ok;
    logic              wr_go;
    logic [PTR_W-1:0]  wbin;
    logic [PTR_W-1:0]  wbin_nx;
    logic [PTR_W-1:0]  rbin_s;
    logic [PTR_W-1:0]  relbin_s;
    logic [PTR_W-1:0]  core_cnt;
    logic [PTR_W-1:0]  user_cnt;
    logic [PTR_W-1:0]  af_off;
    logic [CNT_W-1:0]  total;
    logic [CNT_W-1:0]  af_lim;

    assign ok      = rst_n & prst_n;
    assign wbin_nx = wbin + PTR_W'(1);
    assign rbin_s  = PTR_W'(from_gray(32'(rgray_s)));
    assign relbin_s = PTR_W'(from_gray(32'(relgray_s)));

    // Occupancy seen from the write side.
    assign core_cnt  = wbin - rbin_s;
    assign user_cnt  = wbin - relbin_s;
    assign full_core = (core_cnt == PTR_W'(DEPTH));
    assign wr_go     = ok && !wen_n && !full_core;

    // Advance the write pointer on each accepted write.
    always_ff @(posedge wclk) begin
        if (!ok) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_go) begin
            wbin  <= wbin_nx;
            wgray <= PTR_W'(to_gray(32'(wbin_nx)));
        end
    end

    // Offsets: defaults on full reset, parallel load otherwise.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ae_off <= PTR_W'(DEF_AE_OFF);
            af_off <= PTR_W'(DEF_AF_OFF);
        end else if (cfg_ld) begin
            ae_off <= cfg_ae_off;
            af_off <= cfg_af_off;
        end
    end

    // Threshold flags against the mode-dependent capacity.
    assign total       = CNT_W'(DEPTH) + CNT_W'(ft_mode);
    assign af_lim      = total - CNT_W'(af_off);
    assign almost_full = (CNT_W'(user_cnt) >= af_lim);
    assign half_full   = (CNT_W'(user_cnt) > (total >> 1));

    assign wr_flag = ft_mode ? full_core : !full_core;
    assign waddr   = wbin[ADDR_W-1:0];
    assign we      = wr_go;
endmodule

// File: rtl/xclk_rd_side.sv
// Read-domain control: core read pointer, released pointer, output
// register (standard or fall-through) and the almost-empty flag.
// Assumes: wgray_s is synchronised to rclk; mem_rdata is the word at raddr.
module xclk_rd_side
    import xclk_fifo_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 18,
    localparam int unsigned PTR_W = ADDR_W + 1
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              ft_mode,
    input  logic              ren_n,
    input  logic [PTR_W-1:0]  wgray_s,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [PTR_W-1:0]  ae_off,
    output logic [PTR_W-1:0]  rgray,
    output logic [PTR_W-1:0]  relgray,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] q,
    output logic              out_valid,
    output logic              core_empty,
    output logic              rd_flag,
    output logic              almost_empty
);
    fifo_mode_e        mode;
    logic              is_ft;
    logic              ok;
    logic              load;
    logic              consume;
    logic [PTR_W-1:0]  rbin;
    logic [PTR_W-1:0]  rbin_nx;
    logic [PTR_W-1:0]  relbin;
    logic [PTR_W-1:0]  relbin_nx;
    logic [PTR_W-1:0]  wbin_s;
    logic [PTR_W-1:0]  ucnt;

    assign mode      = fifo_mode_e'(ft_mode);
    assign is_ft     = (mode == MODE_FWFT);
    assign ok        = rst_n & prst_n;
    assign wbin_s    = PTR_W'(from_gray(32'(wgray_s)));
    assign rbin_nx   = rbin + PTR_W'(1);
    assign relbin_nx = relbin + PTR_W'(1);
    assign core_empty = (rbin == wbin_s);

    // consume: a word leaves the block; load: a word leaves core memory.
    always_comb begin
        if (is_ft) begin
            consume = out_valid && !ren_n;
            load    = !core_empty && (!out_valid || !ren_n);
        end else begin
            consume = !ren_n && !core_empty;
            load    = consume;
        end
    end

    // Core and released pointers.
    always_ff @(posedge rclk) begin
        if (!ok) begin
            rbin    <= '0;
            rgray   <= '0;
            relbin  <= '0;
            relgray <= '0;
        end else begin
            if (load) begin
                rbin  <= rbin_nx;
                rgray <= PTR_W'(to_gray(32'(rbin_nx)));
            end
            if (consume) begin
                relbin  <= relbin_nx;
                relgray <= PTR_W'(to_gray(32'(relbin_nx)));
            end
        end
    end

    // Output word register and its valid bit.
    always_ff @(posedge rclk) begin
        if (!ok) begin
            q         <= '0;
            out_valid <= 1'b0;
        end else begin
            if (load) begin
                q <= mem_rdata;
            end
            if (!is_ft) begin
                out_valid <= 1'b0;
            end else if (load) begin
                out_valid <= 1'b1;
            end else if (consume) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign ucnt         = wbin_s - relbin;
    assign almost_empty = (ucnt <= ae_off);
    assign rd_flag      = is_ft ? !out_valid : !core_empty;
    assign raddr        = rbin[ADDR_W-1:0];
endmodule

// File: rtl/xclk_fifo.sv
// Dual-clock FIFO top: storage array, pointer synchronisers and the two
// domain controllers.
// Assumes: ft_mode and offsets are static during traffic; resets are held
// for several cycles of both clocks.
module xclk_fifo #(
    parameter int unsigned DATA_W     = 18,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DEF_AE_OFF = 2,
    parameter int unsigned DEF_AF_OFF = 2,
    localparam int unsigned PTR_W     = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              ft_mode,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ren_n,
    input  logic              cfg_ld,
    input  logic [PTR_W-1:0]  cfg_ae_off,
    input  logic [PTR_W-1:0]  cfg_af_off,
    output logic [DATA_W-1:0] q,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              almost_empty,
    output logic              almost_full,
    output logic              half_full
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned N_R2W = 2;

    logic                          ok_all;
    logic [PTR_W-1:0]              wgray;
    logic [PTR_W-1:0]              wgray_s;
    logic [PTR_W-1:0]              rgray;
    logic [PTR_W-1:0]              relgray;
    logic [N_R2W-1:0][PTR_W-1:0]   r2w_src;
    logic [N_R2W-1:0][PTR_W-1:0]   r2w_dst;
    logic [ADDR_W-1:0]             waddr;
    logic [ADDR_W-1:0]             raddr;
    logic                          we;
    logic                          full_core;
    logic                          core_empty;
    logic                          out_valid;
    logic [PTR_W-1:0]              ae_off;
    logic [DATA_W-1:0]             mem_rdata;
    logic [DATA_W-1:0]             mem [DEPTH];

    assign ok_all = rst_n & prst_n;

    // Storage array written on the write clock.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= din;
        end
    end

    assign mem_rdata = mem[raddr];

    // Write pointer into the read domain.
    xclk_sync #(.W(PTR_W)) u_sync_w2r (
        .clk   (rclk),
        .rst_n (ok_all),
        .d     (wgray),
        .q     (wgray_s)
    );

    // Core and released read pointers into the write domain.
    assign r2w_src[0] = rgray;
    assign r2w_src[1] = relgray;

    for (genvar gi = 0; gi < N_R2W; gi++) begin : g_r2w
        xclk_sync #(.W(PTR_W)) u_sync (
            .clk   (wclk),
            .rst_n (ok_all),
            .d     (r2w_src[gi]),
            .q     (r2w_dst[gi])
        );
    end

    xclk_wr_side #(
        .ADDR_W     (ADDR_W),
        .DEF_AE_OFF (DEF_AE_OFF),
        .DEF_AF_OFF (DEF_AF_OFF)
    ) u_wr (
        .wclk        (wclk),
        .rst_n       (rst_n),
        .prst_n      (prst_n),
        .ft_mode     (ft_mode),
        .wen_n       (wen_n),
        .cfg_ld      (cfg_ld),
        .cfg_ae_off  (cfg_ae_off),
        .cfg_af_off  (cfg_af_off),
        .rgray_s     (r2w_dst[0]),
        .relgray_s   (r2w_dst[1]),
        .wgray       (wgray),
        .waddr       (waddr),
        .we          (we),
        .full_core   (full_core),
        .wr_flag     (wr_flag),
        .almost_full (almost_full),
        .half_full   (half_full),
        .ae_off      (ae_off)
    );

    xclk_rd_side #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .rclk         (rclk),
        .rst_n        (rst_n),
        .prst_n       (prst_n),
        .ft_mode      (ft_mode),
        .ren_n        (ren_n),
        .wgray_s      (wgray_s),
        .mem_rdata    (mem_rdata),
        .ae_off       (ae_off),
        .rgray        (rgray),
        .relgray      (relgray),
        .raddr        (raddr),
        .q            (q),
        .out_valid    (out_valid),
        .core_empty   (core_empty),
        .rd_flag      (rd_flag),
        .almost_empty (almost_empty)
    );
endmodule

// File: rtl/xclk_fifo_chk.sv
// Protocol checks for the dual-clock FIFO, attached by bind.
module xclk_fifo_chk #(
    parameter int unsigned PTR_W  = 5,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 18
) (
    input logic              wclk,
    input logic              rclk,
    input logic              ok_all,
    input logic              ft_mode,
    input logic              wen_n,
    input logic              ren_n,
    input logic              full_core,
    input logic              core_empty,
    input logic              out_valid,
    input logic [DATA_W-1:0] q,
    input logic [PTR_W-1:0]  wgray,
    input logic [ADDR_W-1:0] raddr
);
    AST_FULL_WRITE_DROPPED: assert property (@(posedge wclk) disable iff (!ok_all)
        (full_core && !wen_n) |=> $stable(wgray)); // R6

    AST_WGRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (!ok_all)
        $countones(wgray ^ $past(wgray)) <= 1); // R3

    AST_EMPTY_READ_HOLDS: assert property (@(posedge rclk) disable iff (!ok_all)
        (!ft_mode && core_empty && !ren_n) |=> ($stable(q) && $stable(raddr))); // R10

    AST_HEAD_HELD: assert property (@(posedge rclk) disable iff (!ok_all)
        (ft_mode && out_valid && ren_n) |=> ($stable(q) && out_valid)); // R4

    AST_HEAD_FILLS: assert property (@(posedge rclk) disable iff (!ok_all)
        (ft_mode && !core_empty && !out_valid) |=> out_valid); // R4
endmodule

bind xclk_fifo xclk_fifo_chk #(
    .PTR_W  (PTR_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .wclk       (wclk),
    .rclk       (rclk),
    .ok_all     (ok_all),
    .ft_mode    (ft_mode),
    .wen_n      (wen_n),
    .ren_n      (ren_n),
    .full_core  (full_core),
    .core_empty (core_empty),
    .out_valid  (out_valid),
    .q          (q),
    .wgray      (wgray),
    .raddr      (raddr)
);

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WCLK_PERIOD = 14;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prst_n = 1'b1;
    logic        ft_mode = 1'b0;
    logic        wen_n = 1'b1;
    logic [17:0] din = '0;
    logic        ren_n = 1'b1;
    logic        cfg_ld = 1'b0;
    logic [4:0]  cfg_ae_off = '0;
    logic [4:0]  cfg_af_off = '0;
    logic [17:0] q;
    logic        rd_flag, wr_flag, almost_empty, almost_full, half_full;

    int checks = 0;
    int fails = 0;
    logic [17:0] sb[$];
    bit pend = 0;

    always #(CLK_PERIOD / 2) rclk = ~rclk;
    always #(WCLK_PERIOD / 2) wclk = ~wclk;

    xclk_fifo u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .prst_n(prst_n),
        .ft_mode(ft_mode), .wen_n(wen_n), .din(din), .ren_n(ren_n),
        .cfg_ld(cfg_ld), .cfg_ae_off(cfg_ae_off), .cfg_af_off(cfg_af_off),
        .q(q), .rd_flag(rd_flag), .wr_flag(wr_flag),
        .almost_empty(almost_empty), .almost_full(almost_full),
        .half_full(half_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmp_pop(input string req);
        logic [17:0] e;
        if (sb.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL %s actual=%0h expected=<none>", req, q);
        end else begin
            e = sb.pop_front();
            chk(req, 32'(q), 32'(e));
        end
    endtask

    // Monitor: compare read results against the scoreboard queue.
    always @(negedge rclk) begin
        if (!rst_n || !prst_n) begin
            pend = 0;
        end else begin
            if (pend) begin
                cmp_pop("R3 read order");
                pend = 0;
            end
            if (!ft_mode && !ren_n && rd_flag) pend = 1;
            if (ft_mode && !ren_n && !rd_flag) cmp_pop("R4 head order");
        end
    end

    task automatic wait_r(input int n);
        repeat (n) @(posedge rclk);
        #1;
    endtask

    task automatic wait_w(input int n);
        repeat (n) @(posedge wclk);
        #1;
    endtask

    task automatic do_reset(input bit full);
        @(posedge wclk); #1;
        if (full) rst_n = 1'b0; else prst_n = 1'b0;
        wait_w(6);
        rst_n = 1'b1;
        prst_n = 1'b1;
        wait_w(3);
    endtask

    // Driver: one write, queued as expected when it should be accepted.
    task automatic wr(input logic [17:0] d, input bit acc);
        @(posedge wclk); #1;
        din = d;
        wen_n = 1'b0;
        @(posedge wclk); #1;
        wen_n = 1'b1;
        if (acc) sb.push_back(d);
    endtask

    task automatic rd(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge rclk); #1;
            ren_n = 1'b0;
            @(posedge rclk); #1;
            ren_n = 1'b1;
        end
        wait_r(2);
    endtask

    task automatic load_ofs(input logic [4:0] n, input logic [4:0] m);
        @(posedge wclk); #1;
        cfg_ae_off = n;
        cfg_af_off = m;
        cfg_ld = 1'b1;
        @(posedge wclk); #1;
        cfg_ld = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge rclk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // Standard mode reset state
        do_reset(1);
        chk("R1 rd_flag", 32'(rd_flag), 0);
        chk("R1 wr_flag", 32'(wr_flag), 1);
        chk("R1 almost_empty", 32'(almost_empty), 1);
        chk("R1 almost_full", 32'(almost_full), 0);
        chk("R1 half_full", 32'(half_full), 0);
        chk("R1 q", 32'(q), 0);

        for (int i = 1; i <= 3; i++) wr(18'h10000 + 18'(i), 1);
        wait_r(6);
        chk("R3 not empty", 32'(rd_flag), 1);
        chk("R3 no fall-through", 32'(q), 0);
        chk("R8 count 3 > n", 32'(almost_empty), 0);
        rd(1);
        chk("R8 count 2 <= n", 32'(almost_empty), 1);
        rd(2);
        chk("R3 empty again", 32'(rd_flag), 0);
        rd(1);
        chk("R10 q held on empty read", 32'(q), 32'h10003);

        // Fill to capacity
        for (int i = 0; i < 13; i++) wr(18'h11000 + 18'(i), 1);
        wait_w(6);
        chk("R9 af at 13", 32'(almost_full), 0);
        chk("R9 hf at 13", 32'(half_full), 1);
        wr(18'h1100D, 1);
        wait_w(6);
        chk("R9 af at 14", 32'(almost_full), 1);
        wr(18'h1100E, 1);
        wr(18'h1100F, 1);
        wait_w(6);
        chk("R5 full std", 32'(wr_flag), 0);
        wr(18'h3BAD0, 0);
        rd(1);
        wait_w(6);
        chk("R7 full clears", 32'(wr_flag), 1);
        rd(6);
        wait_w(6);
        chk("R9 hf at 9", 32'(half_full), 1);
        rd(1);
        wait_w(6);
        chk("R9 hf at 8", 32'(half_full), 0);
        rd(8);
        wait_r(6);
        chk("R6 drained empty", 32'(rd_flag), 0);
        chk("R6 no extra word", 32'(sb.size()), 0);

        // Offsets across partial and full reset
        load_ofs(5'd4, 5'd3);
        wr(18'h22222, 0);
        wr(18'h22223, 0);
        do_reset(0);
        chk("R11 partial clears", 32'(rd_flag), 0);
        for (int i = 0; i < 4; i++) wr(18'h12000 + 18'(i), 1);
        wait_r(6);
        chk("R12 n=4 kept at 4", 32'(almost_empty), 1);
        wr(18'h12004, 1);
        wait_r(6);
        chk("R11 n=4 at 5", 32'(almost_empty), 0);
        rd(5);
        do_reset(1);
        for (int i = 0; i < 3; i++) wr(18'h13000 + 18'(i), 1);
        wait_r(6);
        chk("R11 default n restored", 32'(almost_empty), 0);
        rd(3);

        // Fall-through mode
        ft_mode = 1'b1;
        do_reset(1);
        chk("R2 rd_flag", 32'(rd_flag), 1);
        chk("R2 wr_flag", 32'(wr_flag), 0);
        wr(18'h2A000, 1);
        wait_r(6);
        chk("R4 head valid", 32'(rd_flag), 0);
        chk("R4 head on q", 32'(q), 32'h2A000);
        for (int i = 1; i <= 16; i++) wr(18'h2A000 + 18'(i), 1);
        wait_w(6);
        chk("R5 full at D+1", 32'(wr_flag), 1);
        chk("R9 af ft", 32'(almost_full), 1);
        wr(18'h3BAD1, 0);
        rd(17);
        wait_r(6);
        chk("R4 no head", 32'(rd_flag), 1);
        chk("R5 all D+1 read", 32'(sb.size()), 0);
        rd(1);
        chk("R10 q held ft", 32'(q), 32'h2A010);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule